// File: doc/BRIEF.md
# First-Come Ticket Lock Arbiter

This block gives out one shared lock to several requesters in strict arrival order. It keeps two modular counters. A tail ticket counter hands the next number to each new requester. A serving counter names the ticket that currently owns the lock. Every requester keeps at most one ticket in a small per-requester slot. The requester whose slot ticket equals the serving value is the holder, and its grant line is high.

A requester raises its acquire line for one cycle and waits for its grant. When it is done, it raises its release line for one cycle. The serving counter then advances by one. Only the slot that now matches the serving value gets its grant. No other waiter sees any change, so a handoff wakes exactly one requester. A release from a requester that does not hold the lock has no effect on the lock and produces a one-cycle error flag.

Top module: `qlk_lock_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant` is 0 and `rel_err` is 0.
- R2: An acquire sampled at a clock edge while no one holds or waits for the lock makes that requester's `grant` bit high after the same edge.
- R3: Acquires sampled at the same edge take consecutive tickets with the lowest requester index first. They are therefore served in ascending index order.
- R4: Acquires sampled at different edges are served in the order of those edges, whatever their indices.
- R5: `grant` has at most one bit set at any time (bit i belongs to requester i).
- R6: A set `grant` bit stays set until that requester's release is sampled.
- R7: A release sampled from the holder clears its `grant` bit after that edge. The next requester in line, and only that one, has its bit set after the same edge. With nobody waiting, `grant` becomes 0.
- R8: A release sampled from a requester whose `grant` bit is low leaves `grant` and the queue unchanged. `rel_err` is 1 for exactly the cycle after that edge and 0 after any edge without such a release.
- R9: An acquire from a requester that already waits or holds the lock is ignored and takes no second ticket.
- R10: Ordering stays correct after the ticket counters wrap past 2^TW.
- R11: When the holder raises acquire and release at the same edge, the release takes effect and the acquire is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | N | One-cycle acquire pulse per requester |
| rel_req | input | N | One-cycle release pulse per requester |
| grant | output | N | Registered one-hot lock-held indication |
| rel_err | output | 1 | Registered pulse: a release came from a non-holder |

## Verification
The properties assume that a requester pulses acquire only after its previous tenure has ended. They also assume that the lowest-bit property only applies when the whole queue is empty, which is the case whenever `grant` is 0. The directed stimulus drives acquire and release for one cycle at a time. The repeated, same-edge and foreign-release patterns come only from the R8, R9 and R11 scenarios, whose outcomes the assertions are written to allow. Each scenario drains the queue before the next one starts, so every scenario begins with `grant` at 0.

// File: rtl/qlk_pkg.sv
`timescale 1ns/1ps
package qlk_pkg;
  // Occupancy of one requester's ticket slot
  typedef enum logic {
    SLOT_FREE   = 1'b0,
    SLOT_QUEUED = 1'b1
  } slot_state_e;
endpackage

// File: rtl/qlk_ticket_alloc.sv
`timescale 1ns/1ps
// Hands out consecutive tickets to this cycle's new requesters, lowest index first
module qlk_ticket_alloc #(
  parameter int N  = 4,
  parameter int TW = 3
) (
  input  logic [N-1:0]         acq_req,
  input  logic [N-1:0]         busy,
  input  logic [TW-1:0]        tail,
  output logic [N-1:0]         take,
  output logic [N-1:0][TW-1:0] tkt,
  output logic [TW-1:0]        tail_nxt
);
  logic [TW-1:0] run;

  always_comb begin
    run = tail;
    for (int i = 0; i < N; i++) begin
      take[i] = acq_req[i] & ~busy[i];
      tkt[i]  = run;
      if (take[i]) run = run + 1'b1;
    end
    tail_nxt = run;
  end
endmodule

// File: rtl/qlk_slot.sv
`timescale 1ns/1ps
// One requester's ticket slot; reports whether it becomes head of line next cycle
module qlk_slot
  import qlk_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [TW-1:0] tkt_in,
  input  logic          retire,
  input  logic [TW-1:0] serving_nxt,
  output logic          busy,
  output logic          head_nxt
);
  slot_state_e   state_q, state_n;
  logic [TW-1:0] tkt_q, tkt_n;

  always_comb begin
    state_n = state_q;
    tkt_n   = tkt_q;
    if (retire) state_n = SLOT_FREE;
    if (take) begin
      state_n = SLOT_QUEUED;
      tkt_n   = tkt_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_FREE;
      tkt_q   <= '0;
    end else begin
      state_q <= state_n;
      tkt_q   <= tkt_n;
    end
  end

  assign busy     = (state_q == SLOT_QUEUED);
  assign head_nxt = (state_n == SLOT_QUEUED) && (tkt_n == serving_nxt);
endmodule

// File: rtl/qlk_serve.sv
`timescale 1ns/1ps
// Now-serving counter, release validation and registered outputs
module qlk_serve #(
  parameter int N  = 4,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  rel_req,
  input  logic [N-1:0]  head_nxt,
  output logic [N-1:0]  retire,
  output logic [TW-1:0] serving_nxt,
  output logic [N-1:0]  grant,
  output logic          rel_err
);
  logic [TW-1:0] serving_q;
  logic [N-1:0]  grant_q;
  logic          err_q;

  assign retire      = rel_req & grant_q;
  assign serving_nxt = serving_q + {{(TW-1){1'b0}}, |retire};

  always_ff @(posedge clk) begin
    if (rst) begin
      serving_q <= '0;
      grant_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      serving_q <= serving_nxt;
      grant_q   <= head_nxt;
      err_q     <= |(rel_req & ~grant_q);
    end
  end

  assign grant   = grant_q;
  assign rel_err = err_q;
endmodule

// File: rtl/qlk_lock_mgr.sv
`timescale 1ns/1ps
// Fair ticket lock for N requesters; TW must satisfy 2**TW >= N
module qlk_lock_mgr #(
  parameter int N  = 4,
  parameter int TW = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] acq_req,
  input  logic [N-1:0] rel_req,
  output logic [N-1:0] grant,
  output logic         rel_err
);
  logic [TW-1:0]        tail_q, tail_nxt, serving_nxt;
  logic [N-1:0]         busy, take, retire, head_nxt;
  logic [N-1:0][TW-1:0] tkt;

  qlk_ticket_alloc #(.N(N), .TW(TW)) u_alloc (
    .acq_req (acq_req),
    .busy    (busy),
    .tail    (tail_q),
    .take    (take),
    .tkt     (tkt),
    .tail_nxt(tail_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) tail_q <= '0;
    else     tail_q <= tail_nxt;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    qlk_slot #(.TW(TW)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .take       (take[g]),
      .tkt_in     (tkt[g]),
      .retire     (retire[g]),
      .serving_nxt(serving_nxt),
      .busy       (busy[g]),
      .head_nxt   (head_nxt[g])
    );
  end

  qlk_serve #(.N(N), .TW(TW)) u_serve (
    .clk        (clk),
    .rst        (rst),
    .rel_req    (rel_req),
    .head_nxt   (head_nxt),
    .retire     (retire),
    .serving_nxt(serving_nxt),
    .grant      (grant),
    .rel_err    (rel_err)
  );
endmodule

// File: rtl/qlk_lock_chk.sv
`timescale 1ns/1ps
module qlk_lock_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] acq_req,
  input logic [N-1:0] rel_req,
  input logic [N-1:0] grant,
  input logic         rel_err
);
  logic [N-1:0] acq_low;
  assign acq_low = acq_req & (~acq_req + 1'b1);

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (rel_req & grant) == '0) |=> grant == $past(grant));

  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    ((rel_req & grant) != '0) |=> ((grant & $past(grant)) == '0));

  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    ((rel_req & ~grant) != '0) |=> rel_err);

  p_err_clr_r8: assert property (@(posedge clk) disable iff (rst)
    ((rel_req & ~grant) == '0) |=> !rel_err);

  p_first_low_r3: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && acq_req != '0) |=> grant == $past(acq_low));
endmodule

bind qlk_lock_mgr qlk_lock_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .acq_req(acq_req),
  .rel_req(rel_req),
  .grant  (grant),
  .rel_err(rel_err)
);

// File: tb/tb_qlk_lock_mgr.sv
`timescale 1ns/1ps
module tb_qlk_lock_mgr;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] acq_req = '0;
  logic [N-1:0] rel_req = '0;
  logic [N-1:0] grant;
  logic         rel_err;
  int ntests = 0;
  int nfail  = 0;

  always #2.5 clk = ~clk;

  qlk_lock_mgr #(.N(N), .TW(3)) dut (
    .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
    .grant(grant), .rel_err(rel_err)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive one edge worth of requests, then sample just after that edge
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
    @(negedge clk);
    acq_req = a;
    rel_req = r;
    @(posedge clk);
    #1;
    acq_req = '0;
    rel_req = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grant in reset", grant, '0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 grant after reset", grant, '0);
    chk("R1 rel_err after reset", {3'b0, rel_err}, '0);
  endtask

  task automatic t_single;
    step(4'b0001, '0); chk("R2 free grant", grant, 4'b0001);
    step('0, 4'b0001); chk("R7 release empty", grant, '0);
  endtask

  task automatic t_simul;
    step(4'b1111, '0); chk("R3 lowest first", grant, 4'b0001);
    step('0, 4'b0001); chk("R3 next id1", grant, 4'b0010);
    step('0, 4'b0010); chk("R3 next id2", grant, 4'b0100);
    step('0, 4'b0100); chk("R7 next id3", grant, 4'b1000);
    step('0, 4'b1000); chk("R7 drained", grant, '0);
  endtask

  task automatic t_order;
    step(4'b1000, '0); chk("R2 id3 grant", grant, 4'b1000);
    step(4'b0010, '0);
    step(4'b0100, '0);
    step(4'b0001, '0); chk("R4 still id3", grant, 4'b1000);
    step('0, 4'b1000); chk("R4 second arrival", grant, 4'b0010);
    step('0, 4'b0010); chk("R4 third arrival", grant, 4'b0100);
    step('0, 4'b0100); chk("R4 fourth arrival", grant, 4'b0001);
    step('0, 4'b0001); chk("R4 drained", grant, '0);
  endtask

  task automatic t_hold;
    step(4'b0100, '0);
    step(4'b0011, '0);
    for (int k = 0; k < 5; k++) begin
      step('0, '0);
      chk("R6 held", grant, 4'b0100);
      chk("R5 onehot", {3'b0, $onehot0(grant)}, 4'b0001);
    end
    step('0, 4'b0100); chk("R7 handoff", grant, 4'b0001);
    step('0, 4'b0001); chk("R7 handoff2", grant, 4'b0010);
    step('0, 4'b0010); chk("R7 drained", grant, '0);
  endtask

  task automatic t_badrel;
    step(4'b0001, '0);
    step(4'b0010, '0);
    step('0, 4'b0010);
    chk("R8 waiter rel ignored", grant, 4'b0001);
    chk("R8 err pulse", {3'b0, rel_err}, 4'b0001);
    step('0, '0);
    chk("R8 err clears", {3'b0, rel_err}, '0);
    step('0, 4'b0100);
    chk("R8 idle rel ignored", grant, 4'b0001);
    chk("R8 err idle", {3'b0, rel_err}, 4'b0001);
    step('0, 4'b0001); chk("R8 queue intact", grant, 4'b0010);
    chk("R8 no err good rel", {3'b0, rel_err}, '0);
    step('0, 4'b0010); chk("R8 drained", grant, '0);
  endtask

  task automatic t_dup;
    step(4'b0001, '0);
    step(4'b0010, '0);
    step(4'b0011, '0);
    step(4'b0100, '0);
    step('0, 4'b0001); chk("R9 id1 next", grant, 4'b0010);
    step('0, 4'b0010); chk("R9 id2 not dup", grant, 4'b0100);
    step('0, 4'b0100); chk("R9 no extra ticket", grant, '0);
  endtask

  task automatic t_same;
    step(4'b0001, '0);
    step(4'b0010, '0);
    step(4'b0001, 4'b0001); chk("R11 release wins", grant, 4'b0010);
    step('0, 4'b0010); chk("R11 acquire ignored", grant, '0);
  endtask

  task automatic t_wrap;
    for (int rnd = 0; rnd < 6; rnd++) begin
      if (rnd % 2 == 0) begin
        step(4'b1111, '0);
        chk("R10 wrap first", grant, 4'b0001);
        step('0, 4'b0001); chk("R10 wrap 1", grant, 4'b0010);
        step('0, 4'b0010); chk("R10 wrap 2", grant, 4'b0100);
        step('0, 4'b0100); chk("R10 wrap 3", grant, 4'b1000);
        step('0, 4'b1000); chk("R10 wrap empty", grant, '0);
      end else begin
        step(4'b1000, '0);
        step(4'b0100, '0);
        step(4'b0010, '0);
        step(4'b0001, '0);
        chk("R10 wrap first", grant, 4'b1000);
        step('0, 4'b1000); chk("R10 wrap 1", grant, 4'b0100);
        step('0, 4'b0100); chk("R10 wrap 2", grant, 4'b0010);
        step('0, 4'b0010); chk("R10 wrap 3", grant, 4'b0001);
        step('0, 4'b0001); chk("R10 wrap empty", grant, '0);
      end
    end
  endtask

  initial begin
    #(5 * 100000);
    nfail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_simul();
    t_order();
    t_hold();
    t_badrel();
    t_dup();
    t_same();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule